// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block watches the command bus of a single-data-rate SDRAM device and reports protocol and timing violations. It is passive: it never drives the bus. On every rising clock it samples clock enable, chip select, the three command strobes, the bank address, the auto-precharge/all-banks address bit and the burst-length field of the address. It keeps a model of which banks hold an open row, and it ages every timing event in clock cycles.

A violation is reported in two ways. A per-class sticky flag stays set until reset. One cycle after the offending command, a one-cycle pulse appears together with a 4-bit code. All minimum timings are parameters counted in clocks. The monitor is meant to sit beside a memory controller in simulation or on silicon as a debug aid, so that a broken command stream is caught where it is issued and not by later data corruption.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded from the strobes only when chip select is low and clock enable is high. Chip select high is a no-op whatever the strobes are. With clock enable low, the only command recognised is self-refresh entry (strobes RAS low, CAS low, WE high). Every other clock-enable-low cycle, and every cycle spent in self refresh, is a no-op.
- R2: A mode-register write (strobes 000), an auto refresh (001 with clock enable high) or a self-refresh entry issued while any bank holds an open row raises code 2.
- R3: Any command other than a no-op issued fewer than T_MRD (default 2) clocks after a mode-register write raises code 3.
- R4: A precharge (strobes 010) with the A10 input high closes every bank. With A10 low it closes only the bank on the bank-address input. Precharging a bank that is already idle changes neither its state nor its timers.
- R5: A read (101) or write (100) to a bank with no open row, or an activate (011) to a bank that already has one, raises code 1.
- R6: A read or write to an open bank fewer than T_RCD clocks after its activate raises code 4. An activate fewer than T_RP clocks after that bank was closed raises code 5.
- R7: An activate fewer than T_RC clocks after the same bank's previous activate raises code 6. A precharge that closes an open bank fewer than T_RAS clocks after its activate raises code 7. An activate to a bank different from the last activated one, fewer than T_RRD clocks after that activate, raises code 8.
- R8: A read or write with A10 high starts an auto-precharge burst. While it runs, any read or write raises code 9. The bank is closed at the burst's last cycle, and its T_RP window counts from there.
- R9: The burst length used for the auto-precharge burst comes from address bits 2:0 of the last mode-register write: 0→1, 1→2, 2→4, anything else→8. It is 1 after reset.
- R10: After self-refresh exit (the first clock-enable-high cycle while in self refresh), any command other than a no-op fewer than T_RFC clocks after the exit cycle raises code 10. The exit cycle itself counts as distance 0.
- R11: Sticky bit i-1 is set when a violation of code i occurs, even if it is not the reported one. It is cleared only by reset, and all bits are zero after reset.
- R12: The pulse and code are registered, so they appear in the clock after the command. When several classes fire together, the lowest code is reported. The code is 0 exactly when the pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BAW (2) | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| mode_bl | input | 3 | Address bits 2:0, burst-length field on mode write |
| err_sticky | output | 10 | Sticky flag per violation class |
| err_pulse | output | 1 | One-cycle pulse after an offending command |
| err_code | output | 4 | Lowest violation code of that command, 0 if none |

## Verification
A behavioural model in the bench, built on timestamps and not on counters, predicts pulse, code and sticky flags, and is compared every clock. Directed sequences place each command exactly one cycle inside and exactly on each timing limit. Examples: an activate three clocks after an implied precharge still violates the row-cycle limit but not the precharge limit, and a cycle with two violations separates the priority order from the individual rules. Masked patterns (chip select high, clock enable low, commands during self refresh) are sent while a bank is open, so a decode slip would show as a bank-state or idle error. A precharge of an idle bank followed at once by an activate shows whether the precharge timer was wrongly restarted.

// File: rtl/sdram_mon_pkg.sv
// Shared types for the SDRAM command monitor.
// Assumes: four-bit violation codes, class index = code - 1.
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        C_NOP, C_MRS, C_REF, C_SREF, C_PRE, C_ACT, C_RD, C_WR, C_BST
    } cmd_e;

    localparam int NUM_CLS = 10;

    // Violation codes; lower value wins when several fire together.
    localparam logic [3:0] E_STATE  = 4'd1;
    localparam logic [3:0] E_IDLE   = 4'd2;
    localparam logic [3:0] E_MRD    = 4'd3;
    localparam logic [3:0] E_RCD    = 4'd4;
    localparam logic [3:0] E_RP     = 4'd5;
    localparam logic [3:0] E_RC     = 4'd6;
    localparam logic [3:0] E_RAS    = 4'd7;
    localparam logic [3:0] E_RRD    = 4'd8;
    localparam logic [3:0] E_APLOCK = 4'd9;
    localparam logic [3:0] E_SRX    = 4'd10;

    // Burst length selected by the mode-write address field.
    function automatic logic [3:0] burst_len(input logic [2:0] fld);
        case (fld)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: maps the sampled strobes to a command.
// Assumes: chip select high or self-refresh residency with clock enable
// low gives a no-op; with clock enable low only self-refresh entry decodes.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke,
    input  logic in_sr,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Strobe pattern to command.
    always_comb begin
        cmd = C_NOP;
        if (!cs_n) begin
            if (!cke) begin
                if (!in_sr && {ras_n, cas_n, we_n} == 3'b001) cmd = C_SREF;
            end else begin
                case ({ras_n, cas_n, we_n})
                    3'b000:  cmd = C_MRS;
                    3'b001:  cmd = C_REF;
                    3'b010:  cmd = C_PRE;
                    3'b011:  cmd = C_ACT;
                    3'b100:  cmd = C_WR;
                    3'b101:  cmd = C_RD;
                    3'b110:  cmd = C_BST;
                    default: cmd = C_NOP;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
// Per-bank tracker: open/idle state, saturating ages since the last
// activate and since the last close, and the auto-precharge burst counter.
// Assumes: the caller only raises ap_start_i for an open bank; act_i wins
// over pre_i, which wins over ap_start_i.
module sdram_bank_track #(
    parameter int CW  = 4,
    parameter int BLW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act_i,
    input  logic           pre_i,
    input  logic           ap_start_i,
    input  logic [BLW-1:0] bl_i,
    output logic           open_o,
    output logic [CW-1:0]  act_age_o,
    output logic [CW-1:0]  pre_age_o,
    output logic           ap_busy_o
);

    localparam logic [CW-1:0]  AGE_SAT = '1;
    localparam logic [BLW-1:0] ONE     = BLW'(1);

    logic [BLW-1:0] ap_cnt;

    assign ap_busy_o = (ap_cnt != '0);

    // Bank state, ages and auto-precharge countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o    <= 1'b0;
            act_age_o <= AGE_SAT;
            pre_age_o <= AGE_SAT;
            ap_cnt    <= '0;
        end else begin
            if (act_age_o != AGE_SAT) act_age_o <= act_age_o + 1'b1;
            if (pre_age_o != AGE_SAT) pre_age_o <= pre_age_o + 1'b1;
            if (act_i) begin
                open_o    <= 1'b1;
                act_age_o <= CW'(1);
                ap_cnt    <= '0;
            end else if (pre_i) begin
                if (open_o) begin
                    open_o    <= 1'b0;
                    pre_age_o <= CW'(1);
                    ap_cnt    <= '0;
                end
            end else if (ap_start_i) begin
                if (bl_i == ONE) begin
                    open_o    <= 1'b0;
                    pre_age_o <= CW'(1);
                    ap_cnt    <= '0;
                end else begin
                    ap_cnt <= bl_i - ONE;
                end
            end else if (ap_cnt != '0) begin
                ap_cnt <= ap_cnt - ONE;
                if (ap_cnt == ONE) begin
                    open_o    <= 1'b0;
                    pre_age_o <= CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
// SDRAM command monitor top: decodes the bus, tracks each bank, ages the
// global events (mode write, last activate, self-refresh exit) and reports
// violations as a registered pulse + code and per-class sticky flags.
// Assumes: all timing parameters are at least 1 and fit the age counters.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RC   = 9,
    parameter int T_RAS  = 6,
    parameter int T_RRD  = 2,
    parameter int T_MRD  = 2,
    parameter int T_RFC  = 9,
    parameter int BL_MAX = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [$clog2(NBANK)-1:0] ba,
    input  logic                     a10,
    input  logic [2:0]               mode_bl,
    output logic [NUM_CLS-1:0]       err_sticky,
    output logic                     err_pulse,
    output logic [3:0]               err_code
);

    localparam int BAW   = $clog2(NBANK);
    localparam int T_M1  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int T_M2  = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int T_M3  = (T_RRD > T_MRD) ? T_RRD : T_MRD;
    localparam int T_M4  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_M5  = (T_M3 > T_RFC) ? T_M3 : T_RFC;
    localparam int T_MAX = (T_M4 > T_M5) ? T_M4 : T_M5;
    localparam int CW    = $clog2(T_MAX + 1);
    localparam int BLW   = $clog2(BL_MAX + 1);

    localparam logic [CW-1:0] AGE_SAT = '1;
    localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
    localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
    localparam logic [CW-1:0] L_MRD = CW'(T_MRD);
    localparam logic [CW-1:0] L_RFC = CW'(T_RFC);

    cmd_e               cmd;
    logic               in_sr;
    logic [CW-1:0]      srx_age, mrs_age, any_act_age;
    logic [BAW-1:0]     last_bank;
    logic [BLW-1:0]     bl_reg;
    logic [NBANK-1:0]   open_v, ap_busy, act_hit, pre_hit, ap_hit;
    logic [CW-1:0]      act_age [NBANK];
    logic [CW-1:0]      pre_age [NBANK];
    logic [NUM_CLS-1:0] viol;
    logic [3:0]         first_code;
    logic               is_cas, srx_win;

    sdram_cmd_decode u_dec (
        .cke(cke), .in_sr(in_sr), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    assign is_cas  = (cmd == C_RD) || (cmd == C_WR);
    assign srx_win = (in_sr && cke) || (srx_age < L_RFC);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign act_hit[b] = (cmd == C_ACT) && (ba == BAW'(b));
            assign pre_hit[b] = (cmd == C_PRE) && (a10 || ba == BAW'(b));
            assign ap_hit[b]  = is_cas && a10 && (ba == BAW'(b)) && open_v[b];
            sdram_bank_track #(.CW(CW), .BLW(BLW)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .act_i(act_hit[b]), .pre_i(pre_hit[b]), .ap_start_i(ap_hit[b]),
                .bl_i(bl_reg), .open_o(open_v[b]),
                .act_age_o(act_age[b]), .pre_age_o(pre_age[b]),
                .ap_busy_o(ap_busy[b])
            );
        end
    endgenerate

    // Rule checks on the current command; bit i flags code i+1.
    always_comb begin
        viol = '0;
        if (cmd != C_NOP) begin
            if (mrs_age < L_MRD) viol[E_MRD-1] = 1'b1;
            if (srx_win)         viol[E_SRX-1] = 1'b1;
        end
        case (cmd)
            C_MRS, C_REF, C_SREF: if (|open_v) viol[E_IDLE-1] = 1'b1;
            C_ACT: begin
                if (open_v[ba])            viol[E_STATE-1] = 1'b1;
                if (pre_age[ba] < L_RP)    viol[E_RP-1]    = 1'b1;
                if (act_age[ba] < L_RC)    viol[E_RC-1]    = 1'b1;
                if (ba != last_bank && any_act_age < L_RRD) viol[E_RRD-1] = 1'b1;
            end
            C_RD, C_WR: begin
                if (!open_v[ba])                viol[E_STATE-1] = 1'b1;
                else if (act_age[ba] < L_RCD)   viol[E_RCD-1]   = 1'b1;
                if (|ap_busy)                   viol[E_APLOCK-1] = 1'b1;
            end
            C_PRE: begin
                for (int b = 0; b < NBANK; b++)
                    if (pre_hit[b] && open_v[b] && act_age[b] < L_RAS)
                        viol[E_RAS-1] = 1'b1;
            end
            default: ;
        endcase
    end

    // Lowest active class gives the reported code.
    always_comb begin
        first_code = '0;
        for (int i = NUM_CLS - 1; i >= 0; i--)
            if (viol[i]) first_code = 4'(i + 1);
    end

    // Global event ages, self-refresh residency and burst length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr       <= 1'b0;
            srx_age     <= AGE_SAT;
            mrs_age     <= AGE_SAT;
            any_act_age <= AGE_SAT;
            last_bank   <= '0;
            bl_reg      <= BLW'(1);
        end else begin
            if (srx_age != AGE_SAT)     srx_age     <= srx_age + 1'b1;
            if (mrs_age != AGE_SAT)     mrs_age     <= mrs_age + 1'b1;
            if (any_act_age != AGE_SAT) any_act_age <= any_act_age + 1'b1;
            if (in_sr && cke) begin
                in_sr   <= 1'b0;
                srx_age <= CW'(1);
            end
            if (cmd == C_SREF) in_sr <= 1'b1;
            if (cmd == C_MRS) begin
                mrs_age <= CW'(1);
                bl_reg  <= BLW'(burst_len(mode_bl));
            end
            if (cmd == C_ACT) begin
                any_act_age <= CW'(1);
                last_bank   <= ba;
            end
        end
    end

    // Registered report: pulse, code, sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse  <= 1'b0;
            err_code   <= '0;
            err_sticky <= '0;
        end else begin
            err_pulse  <= |viol;
            err_code   <= first_code;
            err_sticky <= err_sticky | viol;
        end
    end

endmodule

// File: rtl/sdram_mon_sva.sv
// Property checker for sdram_cmd_monitor, attached by bind.
// Assumes: T_MRD >= 2 for the mode-gap property.
module sdram_mon_sva
    import sdram_mon_pkg::*;
#(
    parameter int NBANK = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               a10,
    input cmd_e               cmd,
    input logic [NBANK-1:0]   open_v,
    input logic [NBANK-1:0]   ap_busy,
    input logic [NUM_CLS-1:0] err_sticky,
    input logic               err_pulse,
    input logic [3:0]         err_code
);

    // R1: every reported violation stems from a selected cycle
    a_r1_err_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(!cs_n));

    // R2: mode write or refresh with a row open is flagged
    a_r2_busy_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == C_MRS || cmd == C_REF) && |open_v) |=> err_pulse);

    // R3: command right after a mode write is flagged
    a_r3_mode_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_MRS) ##1 (cmd != C_NOP) |=> err_pulse);

    // R4: precharge-all leaves no bank open
    a_r4_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_PRE && a10) |=> (open_v == '0));

    // R8: column command during auto-precharge burst is flagged
    a_r8_ap_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (|ap_busy && (cmd == C_RD || cmd == C_WR)) |=> err_pulse);

    // R11: sticky flags never drop outside reset
    a_r11_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky & $past(err_sticky)) == $past(err_sticky));

    // R12: code is nonzero exactly with the pulse
    a_r12_pulse_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == (err_code != 4'd0));

    // R12: reported class is also recorded sticky
    a_r12_code_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky[int'(err_code) - 1]);

endmodule

bind sdram_cmd_monitor sdram_mon_sva #(.NBANK(NBANK)) u_sva (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a10(a10), .cmd(cmd),
    .open_v(open_v), .ap_busy(ap_busy), .err_sticky(err_sticky),
    .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;

    localparam int T_RCD = 3, T_RP = 3, T_RC = 9, T_RAS = 6;
    localparam int T_RRD = 2, T_MRD = 2, T_RFC = 9;

    logic clk = 0, rst_n = 0;
    logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
    logic [1:0] ba = 0;
    logic [2:0] mode_bl = 0;
    logic [9:0] err_sticky;
    logic err_pulse;
    logic [3:0] err_code;

    int checks = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sdram_cmd_monitor u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .mode_bl(mode_bl),
        .err_sticky(err_sticky), .err_pulse(err_pulse), .err_code(err_code)
    );

    // Reference model: timestamps of events, in command cycles.
    int cyc = 0;
    bit m_open[4];
    int m_act[4], m_pre[4], m_apend[4];
    bit m_ap[4];
    int m_any = -1000, m_lbank = 0, m_mrs = -1000, m_srx = -1000, m_bl = 1;
    bit m_insr = 0;
    bit [9:0] exp_sticky = 0;
    bit exp_pulse = 0;
    int exp_code = 0;

    function automatic string tag_of(input int code);
        case (code)
            1: return "R5";  2: return "R2";  3: return "R3";
            4, 5: return "R6";  6, 7, 8: return "R7";
            9: return "R8";  10: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic model(input bit k, cs, r, c, w, input int b, input bit a,
                         input bit [2:0] f);
        int kd;
        bit [9:0] v;
        v = 0;
        // kinds: 0 nop 1 mrs 2 ref 3 sref 4 pre 5 act 6 rd 7 wr 8 bst
        if (cs) kd = 0;
        else if (!k) kd = (!m_insr && {r, c, w} == 3'b001) ? 3 : 0;
        else if ({r, c, w} == 3'b000) kd = 1;
        else if ({r, c, w} == 3'b001) kd = 2;
        else if ({r, c, w} == 3'b010) kd = 4;
        else if ({r, c, w} == 3'b011) kd = 5;
        else if ({r, c, w} == 3'b100) kd = 7;
        else if ({r, c, w} == 3'b101) kd = 6;
        else if ({r, c, w} == 3'b110) kd = 8;
        else kd = 0;
        if (m_insr && k) begin m_insr = 0; m_srx = cyc; end
        for (int i = 0; i < 4; i++)
            if (m_ap[i] && m_apend[i] < cyc) begin
                m_open[i] = 0; m_pre[i] = m_apend[i]; m_ap[i] = 0;
            end
        if (kd != 0) begin
            if (cyc - m_mrs < T_MRD) v[2] = 1;
            if (cyc - m_srx < T_RFC) v[9] = 1;
        end
        if (kd == 1 || kd == 2 || kd == 3)
            if (m_open[0] | m_open[1] | m_open[2] | m_open[3]) v[1] = 1;
        if (kd == 5) begin
            if (m_open[b]) v[0] = 1;
            if (cyc - m_pre[b] < T_RP) v[4] = 1;
            if (cyc - m_act[b] < T_RC) v[5] = 1;
            if (b != m_lbank && cyc - m_any < T_RRD) v[7] = 1;
        end
        if (kd == 6 || kd == 7) begin
            if (!m_open[b]) v[0] = 1;
            else if (cyc - m_act[b] < T_RCD) v[3] = 1;
            for (int i = 0; i < 4; i++) if (m_ap[i] && m_apend[i] >= cyc) v[8] = 1;
        end
        if (kd == 4)
            for (int i = 0; i < 4; i++)
                if ((a || i == b) && m_open[i] && cyc - m_act[i] < T_RAS) v[6] = 1;
        exp_code = 0;
        for (int i = 9; i >= 0; i--) if (v[i]) exp_code = i + 1;
        exp_pulse = (v != 0);
        exp_sticky |= v;
        // state update
        if (kd == 1) begin
            m_mrs = cyc;
            m_bl = (f == 0) ? 1 : (f == 1) ? 2 : (f == 2) ? 4 : 8;
        end
        if (kd == 3) m_insr = 1;
        if (kd == 5) begin
            m_open[b] = 1; m_act[b] = cyc; m_ap[b] = 0; m_any = cyc; m_lbank = b;
        end
        if (kd == 4)
            for (int i = 0; i < 4; i++)
                if ((a || i == b) && m_open[i]) begin
                    m_open[i] = 0; m_pre[i] = cyc; m_ap[i] = 0;
                end
        if ((kd == 6 || kd == 7) && a && m_open[b]) begin
            if (m_bl == 1) begin m_open[b] = 0; m_pre[b] = cyc; m_ap[b] = 0; end
            else begin m_ap[b] = 1; m_apend[b] = cyc + m_bl - 1; end
        end
        cyc++;
    endtask

    task automatic compare();
        checks++;
        if (err_pulse !== exp_pulse || err_code !== 4'(exp_code) ||
            err_sticky !== exp_sticky) begin
            bad++;
            $display("FAIL %s cycle %0d: pulse/code/sticky got %0b/%0d/%h exp %0b/%0d/%h",
                     tag_of(exp_code != 0 ? exp_code : int'(err_code)), cyc,
                     err_pulse, err_code, err_sticky, exp_pulse, exp_code, exp_sticky);
        end
    endtask

    task automatic issue(input bit k, cs, r, c, w, input int b, input bit a,
                         input bit [2:0] f);
        @(negedge clk);
        compare();
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ba = 2'(b); a10 = a; mode_bl = f;
        model(k, cs, r, c, w, b, a, f);
    endtask

    task automatic want(input int code, input string tag);
        @(posedge clk); #1;
        checks++;
        if (err_code !== 4'(code)) begin
            bad++;
            $display("FAIL %s: code got %0d exp %0d", tag, err_code, code);
        end
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) issue(1, 0, 1, 1, 1, 0, 0, 0);
    endtask
    task automatic act(input int b);            issue(1, 0, 0, 1, 1, b, 0, 0); endtask
    task automatic rd(input int b, input bit a); issue(1, 0, 1, 0, 1, b, a, 0); endtask
    task automatic pre(input int b, input bit a); issue(1, 0, 0, 1, 0, b, a, 0); endtask
    task automatic mrs(input bit [2:0] f);      issue(1, 0, 0, 0, 0, 0, 0, f); endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; m_act[i] = -1000; m_pre[i] = -1000; m_ap[i] = 0; m_apend[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (err_sticky !== 0 || err_pulse !== 0 || err_code !== 0) begin
            bad++;
            $display("FAIL R11 reset: sticky/pulse/code got %h/%0b/%0d exp 0/0/0",
                     err_sticky, err_pulse, err_code);
        end
        @(negedge clk); rst_n = 1;

        // R9 R3: mode write, then an immediate activate
        mrs(3'b010); want(0, "R9");
        act(0);      want(3, "R3");
        nop(10);
        // R1: masked patterns while bank 0 is open
        issue(1, 1, 0, 0, 0, 0, 0, 0); want(0, "R1");
        issue(0, 0, 0, 1, 1, 0, 0, 0); want(0, "R1");
        // R5: bank state errors
        act(0);      want(1, "R5");
        nop(10);
        rd(1, 0);    want(1, "R5");
        // R2: mode write with a row open
        mrs(3'b010); want(2, "R2");
        nop(3);
        // R6 R7: precharge, then too-early activate, read, precharge
        pre(0, 0);   want(0, "R4");
        act(0);      want(5, "R6");
        rd(0, 0);    want(4, "R6");
        pre(0, 0);   want(7, "R7");
        nop(10);
        // R7: activate-to-activate across banks
        act(1);      want(0, "R7");
        act(2);      want(8, "R7");
        nop(10);
        // R4: precharge all, then reads see closed banks
        pre(0, 1);   want(0, "R4");
        nop(4);
        rd(1, 0);    want(1, "R4");
        rd(2, 0);    want(1, "R4");
        pre(0, 0);   want(0, "R4");
        act(0);      want(0, "R4");
        nop(6);
        pre(0, 0);
        nop(3);
        // R9 R7: burst length 1 auto-precharge closes at once; row-cycle limit
        mrs(3'b000); want(0, "R9");
        nop(2);
        act(3);
        nop(2);
        rd(3, 1);    want(0, "R9");
        nop(2);
        act(3);      want(6, "R7");
        nop(6);
        pre(3, 0);
        nop(4);
        // R10: self refresh entry, masked cycles, exit window
        issue(0, 0, 0, 0, 1, 0, 0, 0); want(0, "R10");
        issue(0, 0, 1, 1, 1, 0, 0, 0);
        issue(0, 0, 0, 0, 0, 0, 0, 0); want(0, "R10");
        issue(0, 0, 1, 1, 1, 0, 0, 0);
        nop(3);
        act(0);      want(10, "R10");
        nop(10);
        act(1);      want(0, "R10");
        nop(2);
        // R8 R12: auto-precharge burst of 4
        pre(0, 1);
        nop(4);
        mrs(3'b010);
        nop(2);
        act(0);
        nop(1);
        act(1);      want(0, "R8");
        rd(0, 1);    want(0, "R8");
        nop(1);
        rd(1, 0);    want(9, "R8");
        nop(1);
        act(0);      want(5, "R12");
        nop(2);
        @(negedge clk);
        compare();
        checks++;
        if (err_sticky !== 10'h3FF) begin
            bad++;
            $display("FAIL R11 sticky got %h exp 3ff", err_sticky);
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule